// File: doc/BRIEF.md
# Line-Scan Pixel Pair Sequencer

This block sits behind the converter that digitizes the two analog outputs of a 516-element line-scan detector. For each pixel the converter delivers two words: a reference level first, then a signal level. The block pairs them, subtracts the signal word from the reference word, and limits the result to an unsigned 16-bit range. It keeps count of the physical pixel position in the line. It streams out only the 512 usable pixels and drops two guard pixels at each end. Each output pixel carries a valid strobe, an active index, and start-of-line and end-of-line markers.

A line is framed by a window level driven by the sequencer that also runs the detector. Capture opens on the first clock edge at which the line-start trigger is seen rising while the window is high. It closes when the window falls. A window that closes early discards its partial state, so the next window starts again at the first physical pixel. Once all 516 pixels have been taken in a window, any further converter words are ignored until the window falls. A one-cycle flag reports a window that closed before the full line was captured.

Top module: `lsd_pixel_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `px_vld`, `px_sol`, `px_eol` and `line_short` are 0.
- R2: Converter words are ignored until the clock edge at which `trig` is sampled high after being low and `win` is high. Words are accepted from the following edge on.
- R3: Accepted words alternate, reference first and signal second, as 16-bit two's complement values. The output value is reference minus signal, set to 0 when negative. The largest possible result is 65535.
- R4: Physical pixels 1, 2, 515 and 516 (1-based) produce no output. Physical pixel k for k from 3 to 514 is output with `px_idx` = k-3, so the range is 0 to 511.
- R5: `px_vld` is high for exactly the one cycle after the edge that accepts a pixel's signal word. Cycles with `smp_vld` low neither advance the pairing nor the pixel count.
- R6: `px_sol` is high together with the pixel at index 0, and `px_eol` is high together with the pixel at index 511. Neither is high at any other time.
- R7: When `win` is low at an edge, capture ends and the pixel count and any half-received pair are discarded. The next window begins again at physical pixel 1.
- R8: After 516 pixels have been captured in a window, further words in that window produce no output.
- R9: `line_short` pulses for one cycle after the edge at which `win` is seen low, but only if capture was open and fewer than 516 pixels had been captured. It stays 0 after a full line and after a window with no trigger.
- R10: A trigger rising edge while capture is already open has no effect on the pixel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Line-start trigger level |
| win | input | 1 | Reset window level; high while a line may be captured |
| smp_vld | input | 1 | Converter word valid |
| smp_data | input | 16 | Converter word, two's complement |
| px_vld | output | 1 | Corrected active pixel valid |
| px_idx | output | 9 | Active pixel index 0..511 |
| px_data | output | 16 | Clamped reference-minus-signal value |
| px_sol | output | 1 | Start-of-line marker (index 0) |
| px_eol | output | 1 | End-of-line marker (index 511) |
| line_short | output | 1 | Window closed before the full line was captured |

## Verification
The hardest situation to reach is a window that closes in the middle of a pair. A reference word is already latched but its signal word never arrives. If that half pair leaked into the next window, every later pixel would be formed from mismatched words. The bench closes a window right after a lone reference word and with idle gaps between words, then opens a new window. It checks that the guard pixels are still dropped and that index 0 carries the correct difference. A trigger pulse in the middle of a line and 516-plus extra pairs within one window cover the restart and overrun rules.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic {PH_REF = 1'b0, PH_SIG = 1'b1} phase_e;

  localparam int unsigned LSD_SMP_W    = 16;
  localparam int unsigned LSD_PHYS_PIX = 516;
  localparam int unsigned LSD_GUARD    = 2;
endpackage

// File: rtl/lsd_win_ctl.sv
module lsd_win_ctl #(
  parameter int unsigned PHYS_PIX = 516,
  localparam int unsigned CW = $clog2(PHYS_PIX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          win,
  input  logic          pair_done,
  output logic          accept,
  output logic          clr,
  output logic [CW-1:0] pix_cnt,
  output logic          line_short
);
  logic          trig_q, trig_q_nx;
  logic          cap_q, cap_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          short_q, short_nx;
  logic          full;

  assign full   = (cnt_q == CW'(PHYS_PIX));
  assign accept = cap_q && win && !full;
  assign clr    = !win;

  always_comb begin
    trig_q_nx = trig;
    cap_nx    = cap_q;
    cnt_nx    = cnt_q;
    short_nx  = 1'b0;
    if (!win) begin
      cap_nx   = 1'b0;
      cnt_nx   = '0;
      short_nx = cap_q && !full;
    end else begin
      if (trig && !trig_q) cap_nx = 1'b1;
      if (pair_done && accept) cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      cap_q   <= 1'b0;
      cnt_q   <= '0;
      short_q <= 1'b0;
    end else begin
      trig_q  <= trig_q_nx;
      cap_q   <= cap_nx;
      cnt_q   <= cnt_nx;
      short_q <= short_nx;
    end
  end

  assign pix_cnt    = cnt_q;
  assign line_short = short_q;

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PHYS_PIX));

  // R9
  short_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_q |-> !$past(win));

  // R7
  close_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win |=> (cnt_q == '0) && !cap_q);
endmodule

// File: rtl/lsd_pair_diff.sv
module lsd_pair_diff
  import lsd_pkg::*;
#(
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             accept,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_data,
  output logic             pair_done,
  output logic [SMP_W-1:0] diff
);
  phase_e                  ph_q, ph_nx;
  logic        [SMP_W-1:0] ref_q, ref_nx;
  logic                    take;
  logic signed [SMP_W:0]   wide;

  assign take = accept && smp_vld;

  always_comb begin
    ph_nx  = ph_q;
    ref_nx = ref_q;
    if (clr) begin
      ph_nx = PH_REF;
    end else if (take) begin
      if (ph_q == PH_REF) begin
        ref_nx = smp_data;
        ph_nx  = PH_SIG;
      end else begin
        ph_nx = PH_REF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_REF;
      ref_q <= '0;
    end else begin
      ph_q  <= ph_nx;
      ref_q <= ref_nx;
    end
  end

  assign pair_done = take && !clr && (ph_q == PH_SIG);

  always_comb begin
    wide = $signed({ref_q[SMP_W-1], ref_q}) - $signed({smp_data[SMP_W-1], smp_data});
    if (wide[SMP_W]) diff = '0;
    else             diff = wide[SMP_W-1:0];
  end

  // R3
  pair_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> (ph_q == PH_REF));
endmodule

// File: rtl/lsd_px_out.sv
module lsd_px_out #(
  parameter int unsigned PHYS_PIX = 516,
  parameter int unsigned GUARD    = 2,
  parameter int unsigned SMP_W    = 16,
  localparam int unsigned CW      = $clog2(PHYS_PIX + 1),
  localparam int unsigned ACTIVE  = PHYS_PIX - 2 * GUARD,
  localparam int unsigned IW      = $clog2(ACTIVE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_done,
  input  logic [CW-1:0]    pix_cnt,
  input  logic [SMP_W-1:0] diff,
  output logic             px_vld,
  output logic [IW-1:0]    px_idx,
  output logic [SMP_W-1:0] px_data,
  output logic             px_sol,
  output logic             px_eol
);
  logic             in_act;
  logic [CW-1:0]    act_full;
  logic             vld_nx, sol_nx, eol_nx;
  logic [IW-1:0]    idx_nx;
  logic [SMP_W-1:0] dat_nx;

  assign in_act   = (pix_cnt >= CW'(GUARD)) && (pix_cnt < CW'(PHYS_PIX - GUARD));
  assign act_full = pix_cnt - CW'(GUARD);

  always_comb begin
    vld_nx = pair_done && in_act;
    idx_nx = px_idx;
    dat_nx = px_data;
    sol_nx = 1'b0;
    eol_nx = 1'b0;
    if (vld_nx) begin
      idx_nx = act_full[IW-1:0];
      dat_nx = diff;
      sol_nx = (act_full == '0);
      eol_nx = (act_full == CW'(ACTIVE - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_vld  <= 1'b0;
      px_idx  <= '0;
      px_data <= '0;
      px_sol  <= 1'b0;
      px_eol  <= 1'b0;
    end else begin
      px_vld <= vld_nx;
      px_sol <= sol_nx;
      px_eol <= eol_nx;
      if (vld_nx) begin
        px_idx  <= idx_nx;
        px_data <= dat_nx;
      end
    end
  end

  // R5
  px_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld |=> !px_vld);

  // R6
  sol_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_sol |-> px_vld && (px_idx == '0));

  // R6
  eol_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_eol |-> px_vld && (px_idx == IW'(ACTIVE - 1)));
endmodule

// File: rtl/lsd_pixel_seq.sv
module lsd_pixel_seq
  import lsd_pkg::*;
#(
  parameter int unsigned SMP_W    = LSD_SMP_W,
  parameter int unsigned PHYS_PIX = LSD_PHYS_PIX,
  parameter int unsigned GUARD    = LSD_GUARD,
  localparam int unsigned CW      = $clog2(PHYS_PIX + 1),
  localparam int unsigned IW      = $clog2(PHYS_PIX - 2 * GUARD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             win,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_data,
  output logic             px_vld,
  output logic [IW-1:0]    px_idx,
  output logic [SMP_W-1:0] px_data,
  output logic             px_sol,
  output logic             px_eol,
  output logic             line_short
);
  logic             accept, clr, pair_done;
  logic [CW-1:0]    pix_cnt;
  logic [SMP_W-1:0] diff;

  lsd_win_ctl #(.PHYS_PIX(PHYS_PIX)) u_ctl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .win(win),
    .pair_done(pair_done), .accept(accept), .clr(clr),
    .pix_cnt(pix_cnt), .line_short(line_short)
  );

  lsd_pair_diff #(.SMP_W(SMP_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .clr(clr), .accept(accept),
    .smp_vld(smp_vld), .smp_data(smp_data),
    .pair_done(pair_done), .diff(diff)
  );

  lsd_px_out #(.PHYS_PIX(PHYS_PIX), .GUARD(GUARD), .SMP_W(SMP_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pair_done(pair_done), .pix_cnt(pix_cnt),
    .diff(diff), .px_vld(px_vld), .px_idx(px_idx), .px_data(px_data),
    .px_sol(px_sol), .px_eol(px_eol)
  );

  // R2
  no_px_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !px_vld);
endmodule

// File: tb/lsd_pixel_seq_test.sv
module lsd_pixel_seq_test;
  logic        clk = 1'b0;
  logic        rst_n, trig, win, smp_vld;
  logic [15:0] smp_data;
  logic        px_vld, px_sol, px_eol, line_short;
  logic [8:0]  px_idx;
  logic [15:0] px_data;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int phys;

  always #10 clk = ~clk;

  lsd_pixel_seq uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .win(win), .smp_vld(smp_vld),
    .smp_data(smp_data), .px_vld(px_vld), .px_idx(px_idx), .px_data(px_data),
    .px_sol(px_sol), .px_eol(px_eol), .line_short(line_short)
  );

  // reference word, signal word, expected clamped difference
  localparam logic [47:0] VEC [8] = '{
    {16'sd100,    16'sd200,    16'd0},
    {16'sd32767,  -16'sd32768, 16'd65535},
    {-16'sd5,     -16'sd5,     16'd0},
    {-16'sd32768, 16'sd32767,  16'd0},
    {16'sd1000,   -16'sd1000,  16'd2000},
    {16'sd0,      -16'sd1,     16'd1},
    {-16'sd100,   -16'sd300,   16'd200},
    {16'sd7,      16'sd3,      16'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] d);
    @(negedge clk);
    smp_vld  = v;
    smp_data = d;
  endtask

  task automatic send_pair(input logic [15:0] r, input logic [15:0] s, input int gap);
    drive(1'b1, r);
    for (int g = 0; g < gap; g++) drive(1'b0, 16'h0);
    drive(1'b1, s);
    drive(1'b0, 16'h0);
  endtask

  task automatic check_px(input int p, input logic [15:0] exp, input string req);
    if (p >= 2 && p <= 513) begin
      chk(px_vld == 1'b1, req, px_vld, 1);
      chk(px_idx == 9'(p - 2), req, px_idx, p - 2);
      chk(px_data == exp, req, px_data, exp);
      chk(px_sol == (p == 2), {req, " R6 sol"}, px_sol, p == 2);
      chk(px_eol == (p == 513), {req, " R6 eol"}, px_eol, p == 513);
    end else begin
      chk(px_vld == 1'b0, {req, " R4 guard"}, px_vld, 0);
    end
  endtask

  task automatic open_line();
    @(negedge clk); win = 1'b1;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trig = 1'b0; win = 1'b0; smp_vld = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!px_vld && !px_sol && !px_eol && !line_short, "R1 during reset", px_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!px_vld && !px_sol && !px_eol && !line_short, "R1 after reset", line_short, 0);

    // R2: window high but no trigger -> words ignored
    @(negedge clk); win = 1'b1;
    for (int k = 0; k < 4; k++) begin
      send_pair(16'sd500, 16'sd1, 0);
      chk(px_vld == 1'b0, "R2 no trigger", px_vld, 0);
    end
    @(negedge clk); win = 1'b0;
    @(negedge clk);
    chk(line_short == 1'b0, "R9 no trigger no flag", line_short, 0);

    // Full line walked through the vector table (R3 R4 R5 R6 R10)
    open_line();
    for (int p = 0; p < 516; p++) begin
      logic [47:0] v;
      v = VEC[p % 8];
      if (p == 100) trig = 1'b1;   // R10 mid-line trigger
      if (p == 101) trig = 1'b0;
      send_pair(v[47:32], v[31:16], (p % 5 == 0) ? 2 : 0);
      check_px(p, v[15:0], "R3 R4 R5 R10 line");
    end
    // R8: overrun words in the same window are ignored
    for (int k = 0; k < 4; k++) begin
      send_pair(16'sd900, 16'sd0, 0);
      chk(px_vld == 1'b0, "R8 overrun", px_vld, 0);
    end
    @(negedge clk); win = 1'b0;
    @(negedge clk);
    chk(line_short == 1'b0, "R9 full line no flag", line_short, 0);

    // Short line ending on a lone reference word (R7 R9)
    open_line();
    for (int p = 0; p < 6; p++) begin
      send_pair(16'(p * 10 + 50), 16'(p), 1);
      check_px(p, 16'(p * 9 + 50), "R7 short line");
    end
    drive(1'b1, 16'sd30000);       // dangling reference
    drive(1'b0, 16'h0);
    win = 1'b0;
    @(negedge clk);
    chk(line_short == 1'b1, "R9 short flag", line_short, 1);
    @(negedge clk);
    chk(line_short == 1'b0, "R9 flag one cycle", line_short, 0);

    // R7: next window restarts at physical pixel 1
    open_line();
    for (int p = 0; p < 5; p++) begin
      send_pair(16'sd40, -16'sd2, 1);
      check_px(p, 16'd42, "R7 restart");
    end
    @(negedge clk); win = 1'b0;
    @(negedge clk);
    chk(line_short == 1'b1, "R9 second short", line_short, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule